// File: doc/BRIEF.md
# Serial EEPROM Pin Access Port with Shared-Port Arbitration

This block is a single control register through which software drives a one-bit serial EEPROM by hand. The EEPROM pins are shared with a memory port, so software first sets a request bit. The block then waits until the memory port reports that it is idle. When it is, the block takes the port and raises a ready bit. From that point the chip-select, clock and data-out bits of the register appear on the EEPROM pins, and the EEPROM's data line is sampled into the lowest register bit.

The ready bit has two uses. Its first rise confirms the grant and carries no timing meaning. After the grant, every register write that keeps the request set pulls ready low. Ready then rises again after a fixed delay of `PACE_NS` nanoseconds, converted to clock cycles from `CLK_MHZ`. Software polls ready between clock edges of the serial protocol, so the protocol runs at a safe pace. Software builds the EEPROM command sequence itself. Writing the register with the request bit cleared hands the port back and parks the pins low.

Top module: `seeprom_port`

## Requirements
- R1: After reset the register reads 0x00, `mem_req` and `port_owned` are low, and all three EEPROM output pins are low.
- R2: Register layout: bit 5 is the request, bit 4 is ready (read-only), bit 3 is chip select, bit 2 is the serial clock, bit 1 is data out, and bit 0 is data in (read-only). Bits 7 and 6 always read 0, whatever is written to them. Bits 5..1 read back as last written, apart from ready.
- R3: `mem_req` follows the stored request bit. No grant occurs in any cycle in which `mem_busy` is sampled high.
- R4: With the request stored and `mem_busy` sampled low, `port_owned` rises at the next clock edge. Ready rises at that same edge. A write that sets the request while the port is free therefore gives ready two cycles after the write is presented.
- R5: Once granted, ownership is held whatever `mem_busy` does, until software clears the request.
- R6: While the port is owned, `ee_cs`, `ee_sk` and `ee_dout` equal register bits 3, 2 and 1. While the port is not owned, all three pins are 0.
- R7: While the port is owned, bit 0 shows `ee_din` as sampled at the most recent clock edge. While the port is not owned, bit 0 reads 0.
- R8: A write with the request kept set, made while the port is owned, drops ready at the write edge. Ready rises exactly `PACE_CYC = PACE_NS*CLK_MHZ/1000` edges later (80 cycles at the defaults of 100 MHz and 800 ns).
- R9: A second such write during the pacing interval restarts the interval from that write.
- R10: A write with bit 5 clear releases the port at the write edge. `mem_req`, `port_owned`, ready and all pins go low, and bit 0 stays 0 even when `ee_din` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| mem_req | output | 1 | Request to the shared memory port |
| mem_busy | input | 1 | Memory port is serving another requester |
| port_owned | output | 1 | EEPROM access currently granted |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_dout | output | 1 | Data toward the EEPROM |
| ee_din | input | 1 | Data from the EEPROM |

## Verification
Each result has a fixed due cycle, counted from the edge that samples the stimulus:
- Register contents, release and the drop of ready appear one edge after a write.
- A grant appears one edge after `mem_busy` is seen low with the request stored.
- The sampled data-in bit appears one edge after `ee_din` changes.
- The paced rise of ready appears `PACE_CYC` edges after the write, with ready still low one edge earlier.

The driver stamps each expected observation with its absolute due cycle and keeps the queue in cycle order. The monitor compares only on the falling edge of that exact cycle. An entry found past its cycle, or left over at the end, counts as a failure.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  localparam int unsigned BIT_REQ   = 5;
  localparam int unsigned BIT_READY = 4;
  localparam int unsigned BIT_CS    = 3;
  localparam int unsigned BIT_SK    = 2;
  localparam int unsigned BIT_DO    = 1;
  localparam int unsigned BIT_DI    = 0;

  // bits that read back as written
  localparam logic [7:0] CTL_RW_MASK = 8'h2E;

  function automatic int unsigned pace_cycles(int unsigned clk_mhz, int unsigned pace_ns);
    int unsigned c;
    c = (pace_ns * clk_mhz) / 1000;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/seeprom_grant.sv
module seeprom_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic busy_i,
  input  logic rel_i,
  output logic granted_o,
  output logic granted_d_o,
  output logic grant_evt_o
);
  logic granted_q, granted_d, grant_evt;

  always_comb begin
    grant_evt = ~granted_q & req_i & ~busy_i & ~rel_i;
    if (rel_i)          granted_d = 1'b0;
    else if (grant_evt) granted_d = 1'b1;
    else                granted_d = granted_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) granted_q <= 1'b0;
    else        granted_q <= granted_d;
  end

  assign granted_o   = granted_q;
  assign granted_d_o = granted_d;
  assign grant_evt_o = grant_evt;

  // R3: a new grant needs a stored request and an idle port
  a_r3_grant_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted_q) |-> $past(req_i && !busy_i));

  // R5: grant persists until release
  a_r5_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (granted_q && !rel_i) |=> granted_q);
endmodule

// File: rtl/seeprom_pace.sv
module seeprom_pace #(
  parameter int unsigned PACE_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic running_o,
  output logic done_o
);
  localparam int unsigned CW = (PACE_CYC > 1) ? $clog2(PACE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PACE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, cnt_en;
  logic          done;

  assign done   = run_q & (cnt_q == '0);
  assign cnt_en = start_i | abort_i | run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (abort_i) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (start_i) begin
      run_d = 1'b1;
      cnt_d = LAST;
    end else if (done) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign running_o = run_q;
  assign done_o    = done & ~start_i & ~abort_i;

  // R8: count never exceeds its load value
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= LAST));

  // R9: a start always leaves the timer running
  a_r9_restart_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i) |=> run_q);
endmodule

// File: rtl/seeprom_port.sv
module seeprom_port
  import seeprom_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned PACE_NS = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       mem_req,
  input  logic       mem_busy,
  output logic       port_owned,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_dout,
  input  logic       ee_din
);
  localparam int unsigned PACE_CYC = pace_cycles(CLK_MHZ, PACE_NS);

  logic [7:0] ctl_q;
  logic       ready_q, ready_d;
  logic       din_q, din_d;
  logic       rel, keep_wr;
  logic       granted, granted_d, grant_evt;
  logic       pace_start, pace_run, pace_done;

  assign rel     = reg_wr_en & ~reg_wdata[BIT_REQ];
  assign keep_wr = reg_wr_en &  reg_wdata[BIT_REQ];

  seeprom_grant u_grant (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (ctl_q[BIT_REQ]),
    .busy_i      (mem_busy),
    .rel_i       (rel),
    .granted_o   (granted),
    .granted_d_o (granted_d),
    .grant_evt_o (grant_evt)
  );

  assign pace_start = keep_wr & granted;

  seeprom_pace #(.PACE_CYC(PACE_CYC)) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (pace_start),
    .abort_i   (rel),
    .running_o (pace_run),
    .done_o    (pace_done)
  );

  always_comb begin
    if (rel)             ready_d = 1'b0;
    else if (grant_evt)  ready_d = 1'b1;
    else if (pace_start) ready_d = 1'b0;
    else if (pace_done)  ready_d = 1'b1;
    else                 ready_d = ready_q;
    din_d = granted_d & ee_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (reg_wr_en) ctl_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      din_q   <= 1'b0;
    end else begin
      ready_q <= ready_d;
      din_q   <= din_d;
    end
  end

  always_comb begin
    reg_rdata            = ctl_q & CTL_RW_MASK;
    reg_rdata[BIT_READY] = ready_q;
    reg_rdata[BIT_DI]    = din_q;
  end

  assign mem_req    = ctl_q[BIT_REQ];
  assign port_owned = granted;
  assign ee_cs      = granted & ctl_q[BIT_CS];
  assign ee_sk      = granted & ctl_q[BIT_SK];
  assign ee_dout    = granted & ctl_q[BIT_DO];

  // R6: pins idle without ownership
  a_r6_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !port_owned |-> !(ee_cs || ee_sk || ee_dout));

  // R4: ready implies ownership
  a_r4_ready_owned: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[BIT_READY] |-> port_owned);

  // R8: ready low while pacing runs and right after a paced write
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_wr && port_owned) |=> !reg_rdata[BIT_READY]);
  a_r8_low_while_pacing: assert property (@(posedge clk) disable iff (!rst_n)
    pace_run |-> !reg_rdata[BIT_READY]);

  // R10: release clears everything visible
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> (!mem_req && !port_owned && !reg_rdata[BIT_READY] && !reg_rdata[BIT_DI]));
endmodule

// File: tb/tb_seeprom_port.sv
module tb_seeprom_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       mem_req, mem_busy, port_owned;
  logic       ee_cs, ee_sk, ee_dout, ee_din;

  always #5 clk = ~clk;

  seeprom_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_busy(mem_busy),
    .port_owned(port_owned), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_dout(ee_dout),
    .ee_din(ee_din)
  );

  typedef struct {
    int          cyc;
    logic [12:0] val;
    logic [12:0] msk;
    string       tag;
  } exp_t;

  localparam logic [12:0] FULL  = 13'h1FFF;
  localparam logic [12:0] M_OWN = 13'h0800;
  localparam logic [12:0] M_RD  = 13'h00FF;
  localparam logic [12:0] M_RDY = 13'h0010;
  localparam logic [12:0] M_DI  = 13'h0001;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [12:0] ob(logic r, logic o, logic [2:0] p, logic [7:0] d);
    return {r, o, p, d};
  endfunction

  task automatic expect_at(int off, logic [12:0] msk, logic [12:0] val, string tag);
    exp_t e;
    int   i;
    e.cyc = cyc + off; e.val = val; e.msk = msk; e.tag = tag;
    i = 0;
    while (i < q.size() && q[i].cyc <= e.cyc) i++;
    q.insert(i, e);
  endtask

  // monitor: compares in the exact due cycle
  always @(negedge clk) begin
    logic [12:0] obs;
    obs = {mem_req, port_owned, ee_cs, ee_sk, ee_dout, reg_rdata};
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc || ((obs ^ e.val) & e.msk) != 13'h0) begin
        errors++;
        $display("FAIL %s cycle %0d actual %h expected %h (mask %h)",
                 e.tag, cyc, obs & e.msk, e.val & e.msk, e.msk);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_wr(logic [7:0] d);
    reg_wr_en = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = 8'h00;
    mem_busy = 1'b0; ee_din = 1'b0;
    idle(3);
    rst_n = 1'b1;
    expect_at(1, FULL, 13'h0, "R1");
    idle(2);

    // R2/R3/R6/R7: request while busy, reserved bits written high
    mem_busy = 1'b1; ee_din = 1'b1;
    expect_at(1, FULL, ob(1, 0, 3'b000, 8'h2E), "R2");
    drive_wr(8'hEE);
    expect_at(3, FULL, ob(1, 0, 3'b000, 8'h2E), "R3");
    expect_at(2, M_DI, 13'h0, "R7");
    idle(4);

    // R4: busy drops, grant and first ready
    mem_busy = 1'b0;
    expect_at(1, FULL, ob(1, 1, 3'b111, 8'h3F), "R4");
    idle(3);

    // R5: busy returns, ownership stays
    mem_busy = 1'b1;
    expect_at(4, M_OWN, M_OWN, "R5");
    idle(5);

    // R6/R8: paced write
    expect_at(1, FULL, ob(1, 1, 3'b100, 8'h29), "R6");
    expect_at(80, M_RDY, 13'h0, "R8");
    expect_at(81, M_RDY, M_RDY, "R8");
    drive_wr(8'h28);
    idle(85);

    // R9: restart inside the interval
    expect_at(1, M_RDY, 13'h0, "R9");
    expect_at(81, M_RDY, 13'h0, "R9");
    drive_wr(8'h2A);
    idle(29);
    expect_at(1, FULL, ob(1, 1, 3'b101, 8'h2B), "R9");
    expect_at(80, M_RDY, 13'h0, "R9");
    expect_at(81, M_RDY, M_RDY, "R9");
    drive_wr(8'h2A);
    idle(85);

    // R7: data in follows pin
    ee_din = 1'b0;
    expect_at(1, M_DI, 13'h0, "R7");
    idle(2);
    ee_din = 1'b1;
    expect_at(1, M_DI, M_DI, "R7");
    idle(2);

    // R10: release with data in high
    expect_at(1, FULL, ob(0, 0, 3'b000, 8'h0E), "R10");
    expect_at(3, FULL, ob(0, 0, 3'b000, 8'h0E), "R10");
    drive_wr(8'h0E);
    idle(4);

    // R4: regrant from idle port, ready two cycles after presenting write
    mem_busy = 1'b0;
    expect_at(1, FULL, ob(1, 0, 3'b000, 8'h20), "R4");
    expect_at(2, FULL, ob(1, 1, 3'b000, 8'h31), "R4");
    drive_wr(8'h20);
    idle(4);

    idle(3);
    if (!finished) begin
      finished = 1'b1;
      if (q.size() > 0) begin
        errors += q.size();
        $display("FAIL pending %0d expectations never observed (actual %0d expected 0)",
                 q.size(), q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule